// File: doc/BRIEF.md
# Halt Wake-Up and Skip-Glitch Controller

This block governs the CPU halt state and every way out of it. It reads the halt opcode decode, the interrupt flag and enable vectors, the master interrupt enable, a horizontal-blank DMA trigger and the DMA engine's busy line. It tells the core when it is halted, when to hold the program counter for one increment, when to decrement the return address pushed on interrupt entry, when an interrupt dispatch starts and when the next instruction may run. One clock cycle of the block is one machine cycle of the core.

The block reproduces the halt skip glitch. When halt is decoded while an enabled interrupt is already flagged, the core never sleeps. The next PC increment is suppressed, so the byte after the opcode is fetched twice. If interrupts are enabled, the pushed return address is pulled back onto the halt opcode. A DMA trigger that arrives in the very first halted cycle also causes a skipped increment. That DMA runs at wake-up, and the prefetched instruction then resumes one machine cycle sooner than after any other DMA, ahead of pending interrupts. A parameter selects the device variant. One variant notices a wake-up interrupt one cycle later than the other, except during the first two halted cycles.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After reset, `halted`, `wake`, `pc_hold`, `ret_dec`, `irq_take`, `resume` and `hdma_go` are all 0.
- R2: `halt_op` in the running state with no enabled flag pending sets `halted` in the next cycle. `halted` stays 1 while nothing is pending.
- R3: A halted block leaves halt when any bit of `irq_flags & irq_enable` is 1, whatever `ime` is. In the first cycle after that, `halted` is 0 and `wake` is 1.
- R4: On a wake without DMA and with `ime`=0, the wake cycle shows `resume`=1, `irq_take`=0 and `pc_hold`=0.
- R5: On a wake without DMA and with `ime`=1, the wake cycle shows `irq_take`=1, `resume`=0 and `ret_dec`=0.
- R6: `halt_op` in the running state while an enabled flag is pending never sets `halted`. The next cycle shows `wake`=1 and `pc_hold`=1.
- R7: In that glitch cycle, `ret_dec` and `irq_take` equal `ime`, and `resume` equals its inverse.
- R8: A `hdma_trig` in the first halted cycle makes the wake cycle show `hdma_go`=1, `pc_hold`=1 and `irq_take`=0.
- R9: A `hdma_trig` in a later halted cycle makes the wake cycle show `hdma_go`=1 and `pc_hold`=0.
- R10: After a first-cycle trigger, `resume` is 1 (and `irq_take` 0) in the cycle after the first cycle in which `hdma_busy` is seen low following the wake cycle.
- R11: After a later trigger, that point is one cycle further on. There, `irq_take` = `ime` AND (any enabled flag pending), and `resume` is its inverse.
- R12: With `LATE_DETECT`=1, a flag that appears in halted cycle 2 or later ends halt one cycle later than with `LATE_DETECT`=0. In halted cycles 0 and 1, both variants wake in the same cycle.
- R13: `halt_op` outside the running state and `hdma_trig` outside the halted state have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_op | input | 1 | Halt opcode decoded this cycle |
| irq_flags | input | NUM_IRQ | Interrupt request flags |
| irq_enable | input | NUM_IRQ | Interrupt enable mask |
| ime | input | 1 | Master interrupt enable |
| hdma_trig | input | 1 | Horizontal-blank DMA trigger pulse |
| hdma_busy | input | 1 | DMA engine transfer in progress |
| halted | output | 1 | Core is sleeping in halt |
| wake | output | 1 | Halt ended or was cancelled this cycle |
| pc_hold | output | 1 | Suppress the next PC increment |
| ret_dec | output | 1 | Decrement return address pushed on interrupt entry |
| irq_take | output | 1 | Start interrupt dispatch this cycle |
| resume | output | 1 | Next instruction may execute this cycle |
| hdma_go | output | 1 | Launch the held DMA transfer |

## Verification
The bench runs both device variants side by side so that the one-cycle detection lag shows up as a cycle where one is still halted and the other has woken. Such a lag appears only when the flag arrives at halted cycle 2 or later. It also probes a trigger in halted cycle 0 against cycle 1. A design that mixed these up would hold the PC in the wrong case or resume a cycle off. Glitch entry is checked with both values of `ime`, since a wrong `ret_dec` makes the core return past the halt opcode. Stray triggers and halt opcodes outside their states are also checked, because a leaky design would launch a phantom DMA or sleep again right after a glitch.

// File: rtl/halt_ctl_pkg.sv
package halt_ctl_pkg;

    localparam int HALT_IRQ_W = 5;
    localparam int HALT_CNT_W = 2;

    typedef enum logic [2:0] {
        HS_RUN,
        HS_HALT,
        HS_GLITCH,
        HS_WAKE,
        HS_DMA_WAIT,
        HS_EARLY_GO,
        HS_GAP,
        HS_LATE_GO
    } halt_state_e;

    typedef struct packed {
        logic wake;
        logic pc_hold;
        logic ret_dec;
        logic irq_take;
        logic resume;
        logic hdma_go;
    } halt_out_t;

    // Per-state output decode; ime and pend are sampled live.
    function automatic halt_out_t decode_out(halt_state_e st, logic ime, logic pend,
                                             logic dma_first, logic dma_any);
        halt_out_t o;
        o = '0;
        case (st)
            HS_GLITCH: begin
                o.wake     = 1'b1;
                o.pc_hold  = 1'b1;
                o.ret_dec  = ime;
                o.irq_take = ime;
                o.resume   = ~ime;
            end
            HS_WAKE: begin
                o.wake = 1'b1;
                if (dma_any) begin
                    o.hdma_go = 1'b1;
                    o.pc_hold = dma_first;
                end else begin
                    o.irq_take = ime;
                    o.resume   = ~ime;
                end
            end
            HS_EARLY_GO: o.resume = 1'b1;
            HS_LATE_GO: begin
                o.irq_take = ime & pend;
                o.resume   = ~(ime & pend);
            end
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/irq_wake_detect.sv
module irq_wake_detect #(
    parameter int NUM_IRQ     = halt_ctl_pkg::HALT_IRQ_W,
    parameter int LATE_DETECT = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_flags,
    input  logic [NUM_IRQ-1:0] irq_enable,
    input  logic               early_window,
    output logic               pend,
    output logic               wake_cond
);
    logic [NUM_IRQ-1:0] masked;
    logic               pend_q;

    assign masked = irq_flags & irq_enable;
    assign pend   = |masked;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= pend;
    end

    generate
        if (LATE_DETECT != 0) begin : g_late
            // Lagged view once past the first two halted cycles.
            assign wake_cond = early_window ? pend : pend_q;
        end else begin : g_early
            assign wake_cond = pend;
        end
    endgenerate

    AST_WAKE_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        wake_cond |-> (pend || pend_q)) else $error("wake without request"); // R3
    AST_WINDOW_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
        (early_window && pend) |-> wake_cond) else $error("early window lag"); // R12

endmodule

// File: rtl/halt_timer.sv
module halt_timer #(
    parameter int CNT_W = halt_ctl_pkg::HALT_CNT_W
) (
    input  logic clk,
    input  logic rst,
    input  logic enter,
    input  logic in_halt,
    input  logic hdma_trig,
    output logic early_window,
    output logic dma_first,
    output logic dma_later
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] WIN_END = CNT_W'(2);

    logic [CNT_W-1:0] cnt;

    assign early_window = cnt < WIN_END;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            dma_first <= 1'b0;
            dma_later <= 1'b0;
        end else if (enter) begin
            cnt       <= '0;
            dma_first <= 1'b0;
            dma_later <= 1'b0;
        end else if (in_halt) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (hdma_trig) begin
                if (cnt == '0) dma_first <= 1'b1;
                else           dma_later <= 1'b1;
            end
        end
    end

    AST_FIRST_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_first) |-> $past(in_halt && hdma_trig)) else $error("first flag"); // R8
    AST_TRIG_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!in_halt && !enter) |=> ($stable(dma_first) && $stable(dma_later))) else $error("stray trig"); // R13

endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
    import halt_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      halt_op,
    input  logic      ime,
    input  logic      pend,
    input  logic      wake_cond,
    input  logic      dma_first,
    input  logic      dma_later,
    input  logic      hdma_busy,
    output logic      enter,
    output logic      in_halt,
    output halt_out_t outs
);
    halt_state_e st, st_nx;
    logic        dma_any;

    assign dma_any = dma_first | dma_later;
    assign enter   = (st == HS_RUN) && halt_op && !pend;
    assign in_halt = (st == HS_HALT);
    assign outs    = decode_out(st, ime, pend, dma_first, dma_any);

    always_comb begin
        st_nx = st;
        case (st)
            HS_RUN:      if (halt_op) st_nx = pend ? HS_GLITCH : HS_HALT;
            HS_HALT:     if (wake_cond) st_nx = HS_WAKE;
            HS_GLITCH:   st_nx = HS_RUN;
            HS_WAKE:     st_nx = dma_any ? HS_DMA_WAIT : HS_RUN;
            HS_DMA_WAIT: if (!hdma_busy) st_nx = dma_first ? HS_EARLY_GO : HS_GAP;
            HS_EARLY_GO: st_nx = HS_RUN;
            HS_GAP:      st_nx = HS_LATE_GO;
            HS_LATE_GO:  st_nx = HS_RUN;
            default:     st_nx = HS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= HS_RUN;
        else     st <= st_nx;
    end

    AST_ENTER_HALT: assert property (@(posedge clk) disable iff (rst)
        (st == HS_RUN && halt_op && !pend) |=> in_halt) else $error("no halt"); // R2
    AST_GLITCH_SKIP: assert property (@(posedge clk) disable iff (rst)
        (st == HS_RUN && halt_op && pend) |=> (outs.wake && outs.pc_hold && !in_halt)) else $error("glitch"); // R6
    AST_RETDEC_SOURCE: assert property (@(posedge clk) disable iff (rst)
        outs.ret_dec |-> ($past(halt_op) && ime)) else $error("ret_dec"); // R7
    AST_WAKE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        outs.wake |-> ($past(in_halt) || $past(halt_op))) else $error("wake origin"); // R3
    AST_EARLY_RESUME: assert property (@(posedge clk) disable iff (rst)
        (st == HS_DMA_WAIT && !hdma_busy && dma_first) |=> (outs.resume && !outs.irq_take)) else $error("early go"); // R10

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
    parameter int NUM_IRQ     = halt_ctl_pkg::HALT_IRQ_W,
    parameter int LATE_DETECT = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               halt_op,
    input  logic [NUM_IRQ-1:0] irq_flags,
    input  logic [NUM_IRQ-1:0] irq_enable,
    input  logic               ime,
    input  logic               hdma_trig,
    input  logic               hdma_busy,
    output logic               halted,
    output logic               wake,
    output logic               pc_hold,
    output logic               ret_dec,
    output logic               irq_take,
    output logic               resume,
    output logic               hdma_go
);
    import halt_ctl_pkg::*;

    logic      pend, wake_cond, early_window;
    logic      dma_first, dma_later, enter, in_halt;
    halt_out_t outs;

    irq_wake_detect #(.NUM_IRQ(NUM_IRQ), .LATE_DETECT(LATE_DETECT)) u_detect (
        .clk(clk), .rst(rst), .irq_flags(irq_flags), .irq_enable(irq_enable),
        .early_window(early_window), .pend(pend), .wake_cond(wake_cond)
    );

    halt_timer #(.CNT_W(HALT_CNT_W)) u_timer (
        .clk(clk), .rst(rst), .enter(enter), .in_halt(in_halt), .hdma_trig(hdma_trig),
        .early_window(early_window), .dma_first(dma_first), .dma_later(dma_later)
    );

    halt_fsm u_fsm (
        .clk(clk), .rst(rst), .halt_op(halt_op), .ime(ime), .pend(pend),
        .wake_cond(wake_cond), .dma_first(dma_first), .dma_later(dma_later),
        .hdma_busy(hdma_busy), .enter(enter), .in_halt(in_halt), .outs(outs)
    );

    assign halted   = in_halt;
    assign wake     = outs.wake;
    assign pc_hold  = outs.pc_hold;
    assign ret_dec  = outs.ret_dec;
    assign irq_take = outs.irq_take;
    assign resume   = outs.resume;
    assign hdma_go  = outs.hdma_go;

endmodule

// File: tb/tb_halt_wake_ctrl.sv
`timescale 1ns/1ps
module tb_halt_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h = 1'b0, i = 1'b0, t = 1'b0, b = 1'b0;
    logic [4:0] f = '0, e = 5'h1F;
    int         checks = 0, fails = 0;

    logic [6:0] o0, o1;
    logic       hl0, wk0, ph0, rd0, it0, rs0, hg0;
    logic       hl1, wk1, ph1, rd1, it1, rs1, hg1;

    always #10 clk = ~clk;

    halt_wake_ctrl #(.NUM_IRQ(5), .LATE_DETECT(0)) dut (
        .clk(clk), .rst(rst), .halt_op(h), .irq_flags(f), .irq_enable(e), .ime(i),
        .hdma_trig(t), .hdma_busy(b), .halted(hl0), .wake(wk0), .pc_hold(ph0),
        .ret_dec(rd0), .irq_take(it0), .resume(rs0), .hdma_go(hg0));
    halt_wake_ctrl #(.NUM_IRQ(5), .LATE_DETECT(1)) dut_late (
        .clk(clk), .rst(rst), .halt_op(h), .irq_flags(f), .irq_enable(e), .ime(i),
        .hdma_trig(t), .hdma_busy(b), .halted(hl1), .wake(wk1), .pc_hold(ph1),
        .ret_dec(rd1), .irq_take(it1), .resume(rs1), .hdma_go(hg1));

    assign o0 = {hl0, wk0, ph0, rd0, it0, rs0, hg0};
    assign o1 = {hl1, wk1, ph1, rd1, it1, rs1, hg1};

    // Reference model: 0 run,1 halt,2 glitch,3 wake,4 dma wait,5 early go,6 gap,7 late go
    int ms[2], mc[2];
    bit me[2], md[2], mq[2];

    function automatic logic [6:0] exp_vec(int m, bit im, bit p);
        case (ms[m])
            1: return 7'b1000000;
            2: return {1'b0, 1'b1, 1'b1, im, im, !im, 1'b0};
            3: if (me[m] || md[m]) return {1'b0, 1'b1, me[m], 3'b000, 1'b1};
               else return {1'b0, 1'b1, 2'b00, im, !im, 1'b0};
            5: return 7'b0000010;
            7: return {4'b0000, im && p, !(im && p), 1'b0};
            default: return 7'b0;
        endcase
    endfunction

    task automatic model_step(int m, bit late);
        bit p = |(f & e);
        case (ms[m])
            0: if (h) begin
                   if (p) ms[m] = 2;
                   else begin ms[m] = 1; mc[m] = 0; me[m] = 0; md[m] = 0; end
               end
            1: begin
                   bit c = (mc[m] < 2 || !late) ? p : mq[m];
                   if (t) begin if (mc[m] == 0) me[m] = 1; else md[m] = 1; end
                   if (mc[m] < 3) mc[m]++;
                   if (c) ms[m] = 3;
               end
            2: ms[m] = 0;
            3: ms[m] = (me[m] || md[m]) ? 4 : 0;
            4: if (!b) ms[m] = me[m] ? 5 : 6;
            6: ms[m] = 7;
            default: ms[m] = 0;
        endcase
        mq[m] = p;
    endtask

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic compare(int m, logic [6:0] act);
        string tags[7] = '{"R8", "R4", "R5", "R7", "R6", "R3", "R2"};
        logic [6:0] ex = exp_vec(m, i, |(f & e));
        for (int k = 0; k < 7; k++)
            chk(act[k] === ex[k], tags[k], $sformatf("model v%0d bit%0d", m, k), act[k], ex[k]);
    endtask

    task automatic tick(bit hh, logic [4:0] ff, bit ii, bit tt, bit bb);
        h = hh; f = ff; i = ii; t = tt; b = bb;
        #1;
        compare(0, o0);
        compare(1, o1);
        @(posedge clk);
        model_step(0, 1'b0);
        model_step(1, 1'b1);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int m = 0; m < 2; m++) begin ms[m] = 0; mc[m] = 0; me[m] = 0; md[m] = 0; mq[m] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(o0 == 7'b0 && o1 == 7'b0, "R1", "outputs after reset", o0, 0);

        // R2/R3/R4/R12: wake late in halt, ime low
        tick(1, 0, 0, 0, 0);
        chk(hl0 && hl1, "R2", "halted after halt_op", hl0, 1);
        repeat (3) tick(0, 0, 0, 0, 0);
        chk(hl0 && hl1, "R2", "stays halted", hl1, 1);
        tick(0, 5'h04, 0, 0, 0);
        chk(!hl0 && wk0, "R3", "wake on flag", wk0, 1);
        chk(rs0 && !it0 && !ph0, "R4", "resume without irq", rs0, 1);
        chk(hl1, "R12", "late variant still halted", hl1, 1);
        tick(0, 5'h04, 0, 0, 0);
        chk(wk1 && !hl1, "R12", "late variant wakes one later", wk1, 1);
        tick(0, 0, 0, 0, 0);

        // R5/R12: wake in halted cycle 1 with ime high
        tick(1, 0, 1, 0, 0);
        tick(0, 0, 1, 0, 0);
        tick(0, 5'h01, 1, 0, 0);
        chk(it0 && !rs0 && !rd0, "R5", "irq dispatch on wake", it0, 1);
        chk(wk1 && wk0, "R12", "both wake in cycle 1", wk1, 1);
        tick(0, 0, 1, 0, 0);

        // R6/R7/R13: glitch entry
        tick(1, 5'h02, 1, 0, 0);
        chk(wk0 && ph0 && !hl0, "R6", "glitch skip", ph0, 1);
        chk(rd0 && it0, "R7", "ret_dec with ime", rd0, 1);
        tick(1, 0, 0, 0, 0);
        chk(!hl0 && !hl1, "R13", "halt_op in glitch state ignored", hl0, 0);
        tick(1, 5'h10, 0, 0, 0);
        chk(ph0 && !rd0 && rs0, "R7", "glitch with ime low", rd0, 0);
        tick(0, 0, 0, 0, 0);

        // R8/R10: trigger in first halted cycle
        tick(1, 0, 1, 0, 0);
        tick(0, 0, 1, 1, 0);
        tick(0, 5'h01, 1, 0, 0);
        chk(hg0 && ph0 && !it0, "R8", "first-cycle DMA at wake", ph0, 1);
        tick(0, 5'h01, 1, 0, 1);
        tick(0, 5'h01, 1, 0, 1);
        chk(!rs0, "R10", "held during DMA", rs0, 0);
        tick(0, 5'h01, 1, 0, 0);
        chk(rs0 && !it0, "R10", "early resume before irq", rs0, 1);
        tick(0, 0, 1, 0, 0);

        // R9/R11/R12: trigger later in halt
        tick(1, 0, 1, 0, 0);
        tick(0, 0, 1, 0, 0);
        tick(0, 0, 1, 1, 0);
        tick(0, 5'h08, 1, 0, 0);
        chk(hg0 && !ph0, "R9", "later DMA no skip", ph0, 0);
        chk(hl1, "R12", "late variant lags at cycle 2", hl1, 1);
        tick(0, 5'h08, 1, 0, 0);
        tick(0, 5'h08, 1, 0, 0);
        chk(!rs0 && !it0, "R11", "gap cycle", rs0, 0);
        tick(0, 5'h08, 1, 0, 0);
        chk(it0 && !rs0, "R11", "irq after normal DMA", it0, 1);
        tick(0, 5'h08, 0, 0, 0);
        chk(rs1 && !it1, "R11", "resume after normal DMA ime low", rs1, 1);
        tick(0, 0, 0, 0, 0);

        // R13: trigger while running ignored
        tick(0, 0, 0, 1, 0);
        tick(1, 0, 0, 0, 0);
        tick(0, 5'h01, 0, 0, 0);
        chk(!hg0 && rs0, "R13", "stray trigger ignored", hg0, 0);
        tick(0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0);

        // Random phase checked against the model
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] rf;
            rf = 5'($urandom & $urandom & $urandom & $urandom);
            e  = ($urandom % 4 == 0) ? 5'($urandom) : 5'h1F;
            tick(($urandom % 6) == 0, rf, 1'($urandom), ($urandom % 7) == 0, ($urandom % 3) != 0);
        end
        finish_run();
    end
endmodule